// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a character-oriented asynchronous serial port that a processor reaches through a small register window. The window has a chip select, one register-select line, and read and write strobes. A byte the processor writes goes into a transmit holding register. The holding register hands the byte to a shift register over an internal valid/ready link, and the shift register sends it as a framed serial character. Incoming characters are oversampled at sixteen ticks per bit and assembled in a separate shift register. Each completed byte is then copied into a receiver register for the processor to read.

A control word sets the whole frame format: the baud divisor, the number of data bits (5 to 8), whether a parity bit is present, odd or even parity, and one or two stop bits. A status word reports whether the holding register can take a byte and whether a received byte is waiting. It also reports three receive errors: bad parity, a missing stop bit, and a byte lost because the previous one was still unread.

The register window has no handshake. Back-pressure on transmit is shown by the holding-empty flag. A write made while the holding register is full, and is not being handed to the shifter in that same cycle, is dropped. Back-pressure on receive is shown by the ready flag. A byte that completes while the previous byte is still unread is dropped and flagged as an overrun.

Top module: `async_serial_port`

## Requirements
- R1: With `csel` low, `rdata` is 0 and strobes have no effect. With `csel` high and `rsel`=0, a write loads the transmit holding register from `wdata[7:0]` and a read returns the receiver register, zero-extended. With `rsel`=1, a write loads the control word and a read returns the status word.
- R2: When no character is being sent, `txd` is held at 1.
- R3: The control word has these fields: divisor in bits [7:0]; length code in bits [9:8], where data bits = 5 + code; parity enable in bit [10]; odd parity in bit [11], where 0 means even; two stop bits in bit [12]. A sampling tick occurs every divisor+1 clocks. A transmitted frame is a 0 start bit, then the data bits least-significant first, then the parity bit if enabled, then one or two 1 stop bits. Each bit lasts 16 ticks. Even parity makes the count of ones over data and parity even; odd parity makes it odd.
- R4: Status bit 0 is 1 while the holding register is empty. A write while it is full is ignored, unless the shifter takes the held byte in that same cycle.
- R5: The receiver detects a start edge and confirms it 8 ticks later. A low pulse shorter than half a bit produces no byte.
- R6: Status bit 1 sets when a received byte is copied to the receiver register and clears when the receiver register is read. A received byte is right-aligned to the character length.
- R7: Status bit 2 is 1 when the last byte copied had a parity mismatch, with parity enabled.
- R8: Status bit 3 is 1 when the last byte copied had its first stop bit sampled as 0.
- R9: Status bit 4 sets when a byte completes while status bit 1 is still set. The new byte is dropped and the old byte is kept. The bit clears when the status word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csel | input | 1 | Chip select |
| rsel | input | 1 | Register select: 0 data, 1 control/status |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, 0 unless a selected read |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |

## Verification
The core pattern is a loopback sweep. It covers every character length, every parity setting and both stop-bit counts. Each combination is tried with two data values whose bit patterns differ at the top of the character, so a wrong length or bit order shows up as a wrong serial bit or a wrong masked byte. Separate hand-built frames separate the error cases from one another: a wrong parity bit, a low stop bit, two frames with no read in between, and a short low glitch. Each flags exactly one status bit, or none, so a mix-up between error bits becomes visible. A burst of three back-to-back writes shows whether the full holding register correctly drops the third byte.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int CFG_W = 13;
  localparam int FRM_W = 12;

  typedef struct packed {
    logic       two_stop;
    logic       par_odd;
    logic       par_en;
    logic [1:0] len;
    logic [7:0] div;
  } sp_cfg_t;

  function automatic logic [3:0] data_bits(sp_cfg_t c);
    return 4'd5 + {2'b00, c.len};
  endfunction

  // start bit in [0], data LSB first, optional parity, stop bits as 1s
  function automatic logic [FRM_W-1:0] build_frame(sp_cfg_t c, logic [7:0] d);
    logic [FRM_W-1:0] f;
    logic             p;
    int               n;
    n = int'(data_bits(c));
    f = '1;
    f[0] = 1'b0;
    p = c.par_odd;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        f[i+1] = d[i];
        p = p ^ d[i];
      end
    end
    if (c.par_en) f[n+1] = p;
    return f;
  endfunction

  function automatic logic [3:0] frame_bits(sp_cfg_t c);
    return 4'd2 + data_bits(c) + {3'b000, c.par_en} + {3'b000, c.two_stop};
  endfunction
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= div;
    else                       cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  sp_cfg_t cfg,
  input  logic    in_valid,
  output logic    in_ready,
  input  logic [7:0] in_data,
  output logic    txd,
  output logic    busy
);
  localparam int SUB_W = $clog2(OVS);

  logic [FRM_W-1:0] sr;
  logic [3:0]       left;
  logic [SUB_W-1:0] sub;

  assign in_ready = !busy;
  assign txd      = busy ? sr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '1;
      left <= '0;
      sub  <= '0;
      busy <= 1'b0;
    end else if (!busy) begin
      if (in_valid) begin
        sr   <= build_frame(cfg, in_data);
        left <= frame_bits(cfg) - 4'd1;
        sub  <= '0;
        busy <= 1'b1;
      end
    end else if (tick) begin
      if (sub == SUB_W'(OVS-1)) begin
        sub <= '0;
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          sr   <= {1'b1, sr[FRM_W-1:1]};
          left <= left - 4'd1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  sp_cfg_t    cfg,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr
);
  localparam int SUB_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  logic [SYNC-1:0]  sync;
  logic             rxs;
  rx_st_t           st;
  logic [SUB_W-1:0] sub;
  logic [3:0]       idx;
  logic [7:0]       sr;
  logic             pbit;
  logic [3:0]       dlen;
  logic [7:0]       dshift;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC-2:0], rxd};
  end
  assign rxs = sync[SYNC-1];

  assign dlen   = data_bits(cfg);
  assign dshift = sr >> (4'd8 - dlen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RX_IDLE; sub <= '0; idx <= '0; sr <= '0; pbit <= 1'b0;
      done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!rxs) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: begin
            if (rxs) st <= RX_IDLE;
            else if (sub == SUB_W'(HALF-1)) begin
              st <= RX_BITS; sub <= '0; idx <= '0;
            end else sub <= sub + 1'b1;
          end
          RX_BITS: begin
            if (sub == SUB_W'(OVS-1)) begin
              sub <= '0;
              idx <= idx + 4'd1;
              if (idx < dlen) sr <= {rxs, sr[7:1]};
              else if (idx == dlen && cfg.par_en) pbit <= rxs;
              else begin
                done <= 1'b1;
                st   <= RX_IDLE;
                data <= dshift;
                perr <= cfg.par_en && ((^dshift ^ pbit) != cfg.par_odd);
                ferr <= !rxs;
              end
            end else sub <= sub + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import sp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csel,
  input  logic          rsel,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          txd,
  input  logic          rxd
);
  localparam sp_cfg_t CFG_RST = '{two_stop: 1'b0, par_odd: 1'b0, par_en: 1'b0,
                                   len: 2'b11, div: 8'd0};

  sp_cfg_t    cfg;
  logic [7:0] thr_q;
  logic       thr_full;
  logic       tx_ready, tx_take, tx_busy;
  logic       tick;
  logic       rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_data;
  logic [7:0] rbr;
  logic       rx_ready, perr_q, ferr_q, ovr;
  logic       wr_tx, wr_cfg, rd_rx, rd_st;

  assign wr_tx  = csel && wr_stb && !rsel;
  assign wr_cfg = csel && wr_stb &&  rsel;
  assign rd_rx  = csel && rd_stb && !rsel;
  assign rd_st  = csel && rd_stb &&  rsel;

  sp_baud #(.DIV_W(8)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(wr_cfg), .div(cfg.div), .tick(tick)
  );

  sp_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
    .in_valid(thr_full), .in_ready(tx_ready), .in_data(thr_q),
    .txd(txd), .busy(tx_busy)
  );

  sp_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .rxd(rxd),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  assign tx_take = thr_full && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= CFG_RST;
      thr_q    <= '0;
      thr_full <= 1'b0;
    end else begin
      if (wr_cfg) cfg <= sp_cfg_t'(wdata[CFG_W-1:0]);
      if (tx_take) thr_full <= 1'b0;
      if (wr_tx && (!thr_full || tx_take)) begin
        thr_q    <= wdata[7:0];
        thr_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr <= '0; rx_ready <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0; ovr <= 1'b0;
    end else begin
      if (rd_rx) rx_ready <= 1'b0;
      if (rd_st) ovr <= 1'b0;
      if (rx_done) begin
        if (!rx_ready || rd_rx) begin
          rbr      <= rx_data;
          perr_q   <= rx_perr;
          ferr_q   <= rx_ferr;
          rx_ready <= 1'b1;
        end else begin
          ovr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (csel && rd_stb) begin
      if (rsel) rdata[4:0] = {ovr, ferr_q, perr_q, rx_ready, !thr_full};
      else      rdata[7:0] = rbr;
    end
  end
endmodule

// File: rtl/sp_port_chk.sv
module sp_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csel,
  input logic          rsel,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [DW-1:0] rdata,
  input logic          txd,
  input logic          tx_busy,
  input logic          thr_full,
  input logic [7:0]    thr_q,
  input logic          tx_take,
  input logic          rx_done,
  input logic          rx_ready,
  input logic          ovr
);
  // R1: nothing is driven without chip select
  a_r1_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !csel |-> rdata == '0);

  // R2: line high while no frame is being sent
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R3: a frame opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  // R4: a full holding register keeps its byte against a new write
  a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_full && !tx_take && csel && wr_stb && !rsel) |=> $stable(thr_q) && thr_full);

  // R6: a data read clears ready unless a byte lands in the same cycle
  a_r6_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (csel && rd_stb && !rsel && !rx_done) |=> !rx_ready);

  // R9: a byte completing on an unread one raises overrun
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_ready && !(csel && rd_stb && !rsel)) |=> ovr);
endmodule

bind async_serial_port sp_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csel(csel), .rsel(rsel), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .rdata(rdata), .txd(txd), .tx_busy(tx_busy),
  .thr_full(thr_full), .thr_q(thr_q), .tx_take(tx_take),
  .rx_done(rx_done), .rx_ready(rx_ready), .ovr(ovr)
);

// File: tb/async_serial_port_tb.sv
module async_serial_port_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csel = 1'b0, rsel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          txd;
  logic          loop = 1'b1;
  logic          drv = 1'b1;
  logic          rxd;
  int            checks = 0, errors = 0;
  int            bt = 32;

  assign rxd = loop ? txd : drv;

  always #4 clk = ~clk;

  async_serial_port #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .csel(csel), .rsel(rsel), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic rs, input logic [DW-1:0] v);
    @(negedge clk);
    csel = 1'b1; rsel = rs; wr_stb = 1'b1; wdata = v;
    @(negedge clk);
    csel = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic rd(input logic rs, output logic [DW-1:0] v);
    @(negedge clk);
    csel = 1'b1; rsel = rs; rd_stb = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    csel = 1'b0; rd_stb = 1'b0;
  endtask

  function automatic logic [DW-1:0] mkcfg(int dv, int ln, int pen, int podd, int st2);
    return DW'(dv) | DW'(ln << 8) | DW'(pen << 10) | DW'(podd << 11) | DW'(st2 << 12);
  endfunction

  // bench-side frame: start, data LSB first, parity, stop ones
  function automatic logic [11:0] exp_frame(int n, int pen, int podd, logic [7:0] d);
    logic [11:0] f;
    int ones;
    f = '1; f[0] = 1'b0; ones = 0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (pen != 0) f[n+1] = ((ones % 2) == 1) ? (podd == 0) : (podd != 0);
    return f;
  endfunction

  task automatic send_raw(input logic [11:0] f, input int nb);
    for (int k = 0; k < nb; k++) begin
      drv = f[k];
      repeat (bt) @(negedge clk);
    end
    drv = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic wait_ready(output logic got);
    logic [DW-1:0] s;
    got = 1'b0;
    for (int t = 0; t < 2000 && !got; t++) begin
      rd(1'b1, s);
      got = s[1];
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] s, v;
    logic got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(1'b1, s);
    chk(s == 16'h0001, "R4 reset status", int'(s), 1);
    chk(txd == 1'b1, "R2 reset line", int'(txd), 1);

    // R1: unselected access does nothing
    @(negedge clk);
    rsel = 1'b0; wr_stb = 1'b1; rd_stb = 1'b1; wdata = 16'h0055;
    #1 chk(rdata == '0, "R1 unselected rdata", int'(rdata), 0);
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    repeat (400) @(negedge clk);
    rd(1'b1, s);
    chk(s == 16'h0001 && txd, "R1 unselected write ignored", int'(s), 1);

    // loopback sweep, divisor 1
    bt = 32;
    for (int ln = 0; ln < 4; ln++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 2; k++) begin
            int n, nb, bad, to;
            logic [7:0] d;
            logic [11:0] f;
            n  = 5 + ln;
            d  = 8'((ln * 37 + pm * 11 + st * 5) ^ (k == 0 ? 8'hA5 : 8'h5A));
            f  = exp_frame(n, pm != 0, pm == 2, d);
            nb = 2 + n + (pm != 0) + st;
            wr(1'b1, mkcfg(1, ln, pm != 0, pm == 2, st));
            wr(1'b0, DW'(d));
            to = 0; bad = 0;
            while (txd && to < 2000) begin @(negedge clk); to++; end
            if (to >= 2000) bad = 99;
            for (int b = 0; b < nb; b++) begin
              repeat (b == 0 ? 16 : 32) @(negedge clk);
              if (txd != f[b]) bad++;
            end
            chk(bad == 0, "R3 serial frame bits", bad, 0);
            repeat (24) @(negedge clk);
            chk(txd == 1'b1, "R2 line idle after frame", int'(txd), 1);
            rd(1'b1, s);
            chk(s[4:0] == 5'b00011, "R6 status after loopback", int'(s), 3);
            rd(1'b0, v);
            chk(v == DW'(d & 8'((1 << n) - 1)), "R6 received byte", int'(v), int'(d & 8'((1 << n) - 1)));
            rd(1'b1, s);
            chk(s[1] == 1'b0, "R6 ready cleared by read", int'(s), 1);
          end

    // R4: three back-to-back writes, the third is dropped
    wr(1'b1, mkcfg(1, 3, 0, 0, 0));
    @(negedge clk);
    csel = 1'b1; rsel = 1'b0; wr_stb = 1'b1; wdata = 16'h0011;
    @(negedge clk); wdata = 16'h0022;
    @(negedge clk); wdata = 16'h0033;
    @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b1; rsel = 1'b1;
    #1 chk(rdata[0] == 1'b0, "R4 holding full", int'(rdata), 0);
    @(negedge clk); csel = 1'b0; rd_stb = 1'b0;
    wait_ready(got);
    rd(1'b0, v);
    chk(got && v == 16'h0011, "R4 first byte", int'(v), 'h11);
    wait_ready(got);
    rd(1'b0, v);
    chk(got && v == 16'h0022, "R4 second byte", int'(v), 'h22);
    repeat (800) @(negedge clk);
    rd(1'b1, s);
    chk(s[1:0] == 2'b01, "R4 third write ignored", int'(s), 1);

    // hand-built frames, divisor 3, 8 bits
    loop = 1'b0; bt = 64;
    wr(1'b1, mkcfg(3, 3, 1, 0, 0));
    send_raw({1'b1, 1'b1, 8'h0F, 1'b0}, 11);
    rd(1'b1, s);
    chk(s[4:1] == 4'b0011, "R7 parity error flagged", int'(s[4:1]), 3);
    rd(1'b0, v);
    chk(v == 16'h000F, "R7 byte with bad parity", int'(v), 'h0F);

    send_raw({1'b0, 1'b0, 8'h81, 1'b0}, 11);
    rd(1'b1, s);
    chk(s[4:1] == 4'b0101, "R8 framing error flagged", int'(s[4:1]), 5);
    rd(1'b0, v);
    chk(v == 16'h0081, "R8 byte with low stop", int'(v), 'h81);

    wr(1'b1, mkcfg(3, 3, 1, 1, 0));
    send_raw({1'b1, 1'b1, 8'h0F, 1'b0}, 11);
    rd(1'b1, s);
    chk(s[4:1] == 4'b0001, "R3 odd parity accepted", int'(s[4:1]), 1);
    rd(1'b0, v);

    send_raw({1'b1, 1'b0, 8'h3E, 1'b0}, 11);
    send_raw({1'b1, 1'b0, 8'hC1, 1'b0}, 11);
    rd(1'b1, s);
    chk(s[4] == 1'b1 && s[1] == 1'b1, "R9 overrun set", int'(s), 'h12);
    rd(1'b0, v);
    chk(v == 16'h003E, "R9 old byte kept", int'(v), 'h3E);
    rd(1'b1, s);
    chk(s[4] == 1'b0, "R9 overrun cleared by status read", int'(s), 0);

    // R5: short low glitch
    @(negedge clk); drv = 1'b0;
    repeat (8) @(negedge clk); drv = 1'b1;
    repeat (900) @(negedge clk);
    rd(1'b1, s);
    chk(s[1] == 1'b0, "R5 glitch rejected", int'(s), 0);
    send_raw({1'b1, 1'b0, 8'h5C, 1'b0}, 11);
    rd(1'b0, v);
    chk(v == 16'h005C, "R5 real frame after glitch", int'(v), 'h5C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule